// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block turns message-queue events into interrupt requests for a group of mailbox users. Each user receives two event strobes per queue: one when a new message arrives and one when the queue has room again. The events are latched into a per-user raw status register. A per-user enable mask selects which latched events drive that user's interrupt line.

Software reaches each user through five small registers. Two of them change the enable mask: one sets bits when a 1 is written, the other clears bits when a 1 is written. A raw view shows every latched event. A masked view shows the enabled events and clears bits when a 1 is written. An end-of-interrupt register re-arms the line in pulse mode.

Each user's interrupt output is configured by an input pin. In level mode it stays high while any enabled event is pending. In pulse mode it fires for one cycle and stays silent until end-of-interrupt is written.

Top module: `mbx_irq_ctl`

## Requirements
- R1: A write to register select 0 of user u (`regAddr = {u, 3'd0}`) sets every enable bit whose write-data bit is 1. Bits written as 0 keep their value. Reading select 0 or select 1 returns the enable mask.
- R2: A write to select 1 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: Select 2 reads the raw status. An event latches into raw status on the next clock edge whether or not it is enabled. Writes to select 2 have no effect.
- R4: Select 3 reads the masked status, which equals raw status AND the enable mask.
- R5: Writing select 3 with a bit at 1 clears that bit in raw status, and therefore in masked status. Bits written as 0 are unchanged.
- R6: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: For queue q of user u, input `newMsgEvt[u*4+q]` maps to status bit 2q and `notFullEvt[u*4+q]` maps to bit 2q+1. Events of one user never change another user's status.
- R8: When `pulseMode[u]` is 0, `irqOut[u]` equals the OR of that user's masked status bits.
- R9: When `pulseMode[u]` is 1, `irqOut[u]` is high for exactly one cycle after masked status becomes non-zero. It does not pulse again until end-of-interrupt (select 4) is written.
- R10: In pulse mode, an end-of-interrupt write made while masked status is non-zero produces a pulse in the cycle right after the write. An end-of-interrupt write made while masked status is zero re-arms the line for the next event.
- R11: In level mode, end-of-interrupt writes do not change `irqOut`.
- R12: After reset, all enable masks and status registers are zero and every `irqOut` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| newMsgEvt | input | 16 | New-message strobes, index u*4+q |
| notFullEvt | input | 16 | Queue-not-full strobes, index u*4+q |
| pulseMode | input | 4 | Per-user output mode: 1 = pulse, 0 = level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | {user[1:0], select[2:0]} |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| irqOut | output | 4 | One interrupt line per user |

## Verification
The hardest situations to reach are the two timing races. The first is a pulse-mode end-of-interrupt write that lands while events are still pending. The second is an event that arrives in the same cycle as the write that acknowledges it. The stimulus builds both by placing an event strobe and a register write on the same clock edge. Before the end-of-interrupt write, it leaves masked status non-zero or clears it to zero on purpose. It then watches `irqOut` over the next two cycles. Sweeps over every user and every event bit confirm the bit mapping, the enable masking and the isolation between users.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_EN_SET = 3'd0,
    SEL_EN_CLR = 3'd1,
    SEL_RAW    = 3'd2,
    SEL_MASKED = 3'd3,
    SEL_EOI    = 3'd4
  } regSel_e;

  // strobes from control to datapath, qualified by a one-hot user vector
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic ack;
    logic eoi;
  } strobe_t;
endpackage

// File: rtl/mbx_irq_decode.sv
module mbx_irq_decode
  import mbx_irq_pkg::*;
#(
  parameter int NUM_USERS = 4,
  localparam int USER_W = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int ADDR_W = USER_W + SEL_W
) (
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  output strobe_t              strb,
  output logic [NUM_USERS-1:0] userHot,
  output logic [USER_W-1:0]    rdUser,
  output logic [SEL_W-1:0]     rdSel
);
  logic [SEL_W-1:0] sel;

  assign sel    = regAddr[SEL_W-1:0];
  assign rdUser = regAddr[ADDR_W-1:SEL_W];
  assign rdSel  = sel;

  always_comb begin
    for (int u = 0; u < NUM_USERS; u++) begin
      userHot[u] = (rdUser == USER_W'(u));
    end
  end

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (sel)
        SEL_EN_SET: strb.setEn = 1'b1;
        SEL_EN_CLR: strb.clrEn = 1'b1;
        SEL_MASKED: strb.ack   = 1'b1;
        SEL_EOI:    strb.eoi   = 1'b1;
        default:    strb       = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_irq_core.sv
module mbx_irq_core
  import mbx_irq_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int EVT_W     = 8,
  localparam int USER_W = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_USERS*EVT_W-1:0] evtFlat,
  input  logic [NUM_USERS-1:0]       pulseMode,
  input  strobe_t                    strb,
  input  logic [NUM_USERS-1:0]       userHot,
  input  logic [EVT_W-1:0]           wrData,
  input  logic [USER_W-1:0]          rdUser,
  input  logic [SEL_W-1:0]           rdSel,
  output logic [EVT_W-1:0]           rdData,
  output logic [NUM_USERS*EVT_W-1:0] enMask,
  output logic [NUM_USERS*EVT_W-1:0] rawStat,
  output logic [NUM_USERS-1:0]       irqOut
);
  logic [NUM_USERS*EVT_W-1:0] maskedStat;

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic [EVT_W-1:0] enQ, rawQ, setBits, clrBits, ackBits, evtBits, masked;
    logic armed, anyPend, fire;

    assign setBits = (userHot[u] && strb.setEn) ? wrData : '0;
    assign clrBits = (userHot[u] && strb.clrEn) ? wrData : '0;
    assign ackBits = (userHot[u] && strb.ack)   ? wrData : '0;
    assign evtBits = evtFlat[u*EVT_W +: EVT_W];
    assign masked  = rawQ & enQ;
    assign anyPend = |masked;
    assign fire    = armed && anyPend;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= '0;
        rawQ  <= '0;
        armed <= 1'b1;
      end else begin
        enQ  <= (enQ | setBits) & ~clrBits;
        rawQ <= (rawQ & ~ackBits) | evtBits;
        if (!pulseMode[u] || (userHot[u] && strb.eoi)) armed <= 1'b1;
        else if (fire)                                 armed <= 1'b0;
      end
    end

    assign enMask[u*EVT_W +: EVT_W]     = enQ;
    assign rawStat[u*EVT_W +: EVT_W]    = rawQ;
    assign maskedStat[u*EVT_W +: EVT_W] = masked;
    assign irqOut[u] = pulseMode[u] ? fire : anyPend;
  end

  always_comb begin
    case (rdSel)
      SEL_EN_SET, SEL_EN_CLR: rdData = enMask[rdUser*EVT_W +: EVT_W];
      SEL_RAW:                rdData = rawStat[rdUser*EVT_W +: EVT_W];
      SEL_MASKED:             rdData = maskedStat[rdUser*EVT_W +: EVT_W];
      default:                rdData = '0;
    endcase
  end
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
  import mbx_irq_pkg::*;
#(
  parameter int NUM_USERS  = 4,
  parameter int NUM_QUEUES = 4,
  localparam int EVT_W  = 2 * NUM_QUEUES,
  localparam int USER_W = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int ADDR_W = USER_W + SEL_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_USERS*NUM_QUEUES-1:0] newMsgEvt,
  input  logic [NUM_USERS*NUM_QUEUES-1:0] notFullEvt,
  input  logic [NUM_USERS-1:0]            pulseMode,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [EVT_W-1:0]                regWrData,
  output logic [EVT_W-1:0]                regRdData,
  output logic [NUM_USERS-1:0]            irqOut
);
  strobe_t                    strb;
  logic [NUM_USERS-1:0]       userHot, ackHot, eoiHot;
  logic [USER_W-1:0]          rdUser;
  logic [SEL_W-1:0]           rdSel;
  logic [NUM_USERS*EVT_W-1:0] evtFlat, enMask, rawStat;

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_map
    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
      assign evtFlat[u*EVT_W + 2*q]     = newMsgEvt[u*NUM_QUEUES + q];
      assign evtFlat[u*EVT_W + 2*q + 1] = notFullEvt[u*NUM_QUEUES + q];
    end
  end

  assign ackHot = userHot & {NUM_USERS{strb.ack}};
  assign eoiHot = userHot & {NUM_USERS{strb.eoi}};

  mbx_irq_decode #(.NUM_USERS(NUM_USERS)) u_decode (
    .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb),
    .userHot(userHot), .rdUser(rdUser), .rdSel(rdSel)
  );

  mbx_irq_core #(.NUM_USERS(NUM_USERS), .EVT_W(EVT_W)) u_core (
    .clk(clk), .rstN(rstN), .evtFlat(evtFlat), .pulseMode(pulseMode),
    .strb(strb), .userHot(userHot), .wrData(regWrData),
    .rdUser(rdUser), .rdSel(rdSel), .rdData(regRdData),
    .enMask(enMask), .rawStat(rawStat), .irqOut(irqOut)
  );
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int NUM_USERS = 4,
  parameter int EVT_W     = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_USERS-1:0]       pulseMode,
  input logic [NUM_USERS-1:0]       irqOut,
  input logic [NUM_USERS*EVT_W-1:0] evtFlat,
  input logic [NUM_USERS*EVT_W-1:0] enMask,
  input logic [NUM_USERS*EVT_W-1:0] rawStat,
  input logic [NUM_USERS-1:0]       ackHot,
  input logic [NUM_USERS-1:0]       eoiHot,
  input logic [EVT_W-1:0]           regWrData
);
  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    // R8: level mode follows the pending enabled events
    a_r8_level_follows: assert property (@(posedge clk) disable iff (!rstN)
      !pulseMode[u] |-> (irqOut[u] == |(rawStat[u*EVT_W +: EVT_W] & enMask[u*EVT_W +: EVT_W])));
    // R9: a pulse lasts one cycle unless end-of-interrupt re-arms it
    a_r9_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
      (pulseMode[u] && $stable(pulseMode[u]) && irqOut[u] && !eoiHot[u]) |=> !irqOut[u]);
    // R9: a pulse can only occur while an enabled event is pending
    a_r9_pulse_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[u] |-> (|(rawStat[u*EVT_W +: EVT_W] & enMask[u*EVT_W +: EVT_W])));
    for (genvar b = 0; b < EVT_W; b++) begin : g_b
      // R3, R6: an event always lands in raw status
      a_r3_event_latches: assert property (@(posedge clk) disable iff (!rstN)
        evtFlat[u*EVT_W + b] |=> rawStat[u*EVT_W + b]);
      // R5: acknowledged bit with no new event is cleared
      a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
        (ackHot[u] && regWrData[b] && !evtFlat[u*EVT_W + b]) |=> !rawStat[u*EVT_W + b]);
    end
  end
endmodule

bind mbx_irq_ctl mbx_irq_chk #(.NUM_USERS(NUM_USERS), .EVT_W(EVT_W)) u_chk (.*);

// File: tb/mbx_irq_ctl_test.sv
`timescale 1ns/1ps
module mbx_irq_ctl_test;
  localparam int NU = 4;
  localparam int NQ = 4;
  localparam int EW = 2 * NQ;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NU*NQ-1:0] newMsgEvt = '0, notFullEvt = '0;
  logic [NU-1:0] pulseMode = 4'b1010;
  logic          regWrEn = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [EW-1:0] regWrData = '0;
  logic [EW-1:0] regRdData;
  logic [NU-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_irq_ctl uut (
    .clk(clk), .rstN(rstN), .newMsgEvt(newMsgEvt), .notFullEvt(notFullEvt),
    .pulseMode(pulseMode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int u, input int sel, input logic [EW-1:0] d);
    regWrEn = 1'b1; regAddr = {u[1:0], sel[2:0]}; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input int u, input int sel, input logic [EW-1:0] exp, input string tag);
    regAddr = {u[1:0], sel[2:0]};
    #1;
    check(tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic fire(input int u, input logic [NQ-1:0] nm, input logic [NQ-1:0] nf);
    newMsgEvt[u*NQ +: NQ] = nm; notFullEvt[u*NQ +: NQ] = nf;
    tick();
    newMsgEvt = '0; notFullEvt = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R12 reset state
    check("R12 irq", 32'(irqOut), 0);
    for (int u = 0; u < NU; u++)
      for (int s = 0; s < 4; s++) rdChk(u, s, '0, "R12 regs");

    // R1 / R2 sweep of every enable bit
    for (int u = 0; u < NU; u++) begin
      for (int b = 0; b < EW; b++) begin
        wr(u, 0, EW'(1) << b);
        rdChk(u, 0, EW'(1) << b, "R1 set");
        wr(u, 0, '0);
        rdChk(u, 1, EW'(1) << b, "R1 zero no effect");
        wr(u, 1, '0);
        rdChk(u, 0, EW'(1) << b, "R2 zero no effect");
        wr(u, 1, EW'(1) << b);
        rdChk(u, 0, '0, "R2 clear");
      end
    end

    // R3 / R7 mapping with enables off, R4 masked zero
    for (int u = 0; u < NU; u++) begin
      for (int q = 0; q < NQ; q++) begin
        fire(u, NQ'(1) << q, '0);
        rdChk(u, 2, EW'(1) << (2*q), "R7 new-msg bit");
        rdChk(u, 3, '0, "R4 disabled hidden");
        for (int v = 0; v < NU; v++) if (v != u) rdChk(v, 2, '0, "R7 isolation");
        wr(u, 3, '1);
        fire(u, '0, NQ'(1) << q);
        rdChk(u, 2, EW'(1) << (2*q+1), "R7 not-full bit");
        wr(u, 2, '0);
        rdChk(u, 2, EW'(1) << (2*q+1), "R3 raw write ignored");
        wr(u, 3, '1);
        rdChk(u, 2, '0, "R5 ack clears raw");
      end
    end
    check("R8 idle irq", 32'(irqOut), 0);

    // R4 / R5 / R8 on level user 0
    wr(0, 0, 8'h5A);
    fire(0, '1, '1);
    rdChk(0, 2, 8'hFF, "R3 all latched");
    rdChk(0, 3, 8'hFF & 8'h5A, "R4 masked");
    check("R8 level high", 32'(irqOut), 32'b0001);
    wr(0, 4, 8'h01);
    check("R11 eoi no effect", 32'(irqOut), 32'b0001);
    wr(0, 3, 8'h0F);
    rdChk(0, 2, 8'hF0, "R5 partial ack");
    rdChk(0, 3, 8'hF0 & 8'h5A, "R5 masked after ack");
    wr(0, 3, 8'h00);
    rdChk(0, 2, 8'hF0, "R5 zero no effect");
    wr(0, 3, 8'h50);
    check("R8 level low", 32'(irqOut), 0);
    rdChk(0, 2, 8'hA0, "R5 disabled bits remain");

    // R6 event and ack in same cycle
    newMsgEvt[0] = 1'b1;
    wr(0, 3, 8'h01);
    newMsgEvt = '0;
    rdChk(0, 2, 8'hA1, "R6 event wins");
    wr(0, 3, 8'hFF);

    // R9 / R10 on pulse user 1
    wr(1, 0, 8'hFF);
    check("R9 idle", 32'(irqOut), 0);
    fire(1, 4'b0001, '0);
    check("R9 pulse high", 32'(irqOut), 32'b0010);
    tick();
    check("R9 pulse ends", 32'(irqOut), 0);
    fire(1, '0, 4'b0100);
    check("R9 no repeat", 32'(irqOut), 0);
    tick();
    check("R9 still quiet", 32'(irqOut), 0);
    wr(1, 4, 8'h00);
    check("R10 eoi pending repulse", 32'(irqOut), 32'b0010);
    tick();
    check("R10 repulse one cycle", 32'(irqOut), 0);
    wr(1, 3, 8'hFF);
    wr(1, 4, 8'h00);
    check("R10 eoi idle quiet", 32'(irqOut), 0);
    fire(1, 4'b1000, '0);
    check("R10 rearmed pulse", 32'(irqOut), 32'b0010);
    tick();
    check("R10 rearmed ends", 32'(irqOut), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule